// File: doc/BRIEF.md
# Receive Frame Check Sequence Checker

This block sits behind a packet receiver and checks the 16-bit frame check sequence of every received frame. A frame begins with a one-cycle start strobe that carries the frame length in octets. The octets that follow, which include the two trailing check octets, are fed in one per cycle while a valid strobe is high. The block runs a CRC over all of them. When the last octet has been taken, it decides whether the frame is good and raises a one-cycle end-of-frame interrupt. A status bit records the verdict and holds it until a later reception ends.

Two mode inputs change what happens at the end of a frame. In automatic-acknowledge receive mode, a frame whose check fails is dropped without notice: the interrupt is not raised and the status bit keeps its old value. In automatic-retry transmit mode, the frame being received is the expected acknowledgement, and an acceptance pulse is raised only when its check passes.

Top module: `fcs_rx_checker`

## Requirements
- R1: The CRC uses the polynomial x^16+x^12+x^5+1 with initial value 0. Each octet is processed least significant bit first, so the reflected constant is 0x8408. The check octets follow the payload low byte first. A frame is good when the remainder over all N octets is zero.
- R2: After reset, fcs_valid, eof_irq and ack_accepted are all 0.
- R3: fcs_valid changes only in a cycle where eof_irq is 1. Otherwise it holds its value, including between frames.
- R4: eof_irq is a one-cycle pulse. It is high in the cycle after the clock edge that takes the last octet, or in the cycle after a start strobe whose length is 0.
- R5: A frame of length 0 or 1 raises eof_irq, leaves fcs_valid unchanged and never raises ack_accepted.
- R6: With aack_mode set, a frame of length 2 or more that fails the check raises no eof_irq and leaves fcs_valid unchanged.
- R7: With aack_mode set, a good frame raises eof_irq and sets fcs_valid to 1.
- R8: With aret_mode set, ack_accepted pulses together with eof_irq for a good frame of length 2 or more. A bad frame raises eof_irq with fcs_valid 0 and no ack_accepted.
- R9: A start strobe during a frame abandons that frame with no end event. Counting and CRC restart from the new length.
- R10: Octets strobed outside a frame, or in the start cycle itself, are ignored and do not enter the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Start of a frame; frm_len is valid in this cycle |
| frm_len | input | 7 | Frame length in octets, check octets included |
| oct_valid | input | 1 | oct_data holds a received octet |
| oct_data | input | 8 | Received octet |
| aack_mode | input | 1 | Automatic-acknowledge receive mode |
| aret_mode | input | 1 | Automatic-retry transmit mode; the frame is the expected acknowledgement |
| eof_irq | output | 1 | End-of-frame interrupt pulse |
| ack_accepted | output | 1 | Acknowledgement accepted pulse |
| fcs_valid | output | 1 | Status bit: check result of the last reported frame |

## Verification
The bench covers the boundary lengths 0, 1, 2 and 127. A design that checked length-0 or length-1 frames would overwrite the held status, and one that counted off by one would put the interrupt a cycle early or late. It runs failing frames in acknowledge mode right after a good frame, so a design that updated the status without raising the interrupt shows up as a status that flips to 0. It sends stray octets while idle and in the start cycle, and restarts a frame partway through. A design that let either one into the CRC, or that finished the stale frame, would report the wrong verdict or raise an extra interrupt. In retry mode it checks that the acceptance pulse follows the CRC result and appears only together with the interrupt.

// File: rtl/fcsc_pkg.sv
package fcsc_pkg;
  localparam int LEN_W   = 7;
  localparam int DATA_W  = 8;
  localparam int CRC_W   = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;
  localparam int MIN_CHECK_LEN = 2;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RECV = 1'b1
  } seq_state_t;
endpackage

// File: rtl/fcsc_crc_acc.sv
module fcsc_crc_acc #(
  parameter int DATA_W = fcsc_pkg::DATA_W,
  parameter int CRC_W  = fcsc_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = fcsc_pkg::CRC_POLY_REFL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic              rem_zero_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crc_q;

  // one reflected shift per data bit, LSB first
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][0] ^ din[b];
    assign stage[b+1] = (stage[b] >> 1) ^ (fb ? POLY : '0);
  end

  assign rem_zero_next = (stage[DATA_W] == '0);

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = stage[DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= '0;
    else if (clr || en) crc_q <= crc_d;
  end
endmodule

// File: rtl/fcsc_frame_seq.sv
module fcsc_frame_seq
  import fcsc_pkg::*;
#(
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_start,
  input  logic [LW-1:0] frm_len,
  input  logic          oct_valid,
  output logic          acc_clr,
  output logic          acc_en,
  output logic          fin,
  output logic          short_frm
);
  seq_state_t    st_q, st_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          last_oct;

  assign acc_clr  = frm_start;
  assign acc_en   = (st_q == SEQ_RECV) && oct_valid && !frm_start;
  assign last_oct = acc_en && ((cnt_q + 1'b1) == len_q);
  assign fin      = (frm_start && (frm_len == '0)) || last_oct;
  assign short_frm = frm_start ? 1'b1 : (len_q < LW'(MIN_CHECK_LEN));

  always_comb begin
    st_d  = st_q;
    len_d = len_q;
    cnt_d = cnt_q;
    if (frm_start) begin
      len_d = frm_len;
      cnt_d = '0;
      st_d  = (frm_len == '0) ? SEQ_IDLE : SEQ_RECV;
    end else if (acc_en) begin
      if (last_oct) begin
        st_d  = SEQ_IDLE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (frm_start)           len_q <= len_d;
      if (frm_start || acc_en) cnt_q <= cnt_d;
    end
  end

  assert_cnt_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RECV) |-> (cnt_q < len_q));
  assert_start_ignores_octet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> !acc_en);
endmodule

// File: rtl/fcsc_verdict.sv
module fcsc_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic fin,
  input  logic short_frm,
  input  logic crc_good,
  input  logic aack_mode,
  input  logic aret_mode,
  output logic eof_irq,
  output logic ack_accepted,
  output logic fcs_valid
);
  logic eof_d, ack_d, stat_d, checked;

  assign checked = fin && !short_frm;

  always_comb begin
    eof_d  = fin && (short_frm || crc_good || !aack_mode);
    ack_d  = checked && aret_mode && crc_good;
    stat_d = fcs_valid;
    if (checked && eof_d) stat_d = crc_good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_irq      <= 1'b0;
      ack_accepted <= 1'b0;
      fcs_valid    <= 1'b0;
    end else begin
      eof_irq      <= eof_d;
      ack_accepted <= ack_d;
      fcs_valid    <= stat_d;
    end
  end

  assert_aack_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (checked && aack_mode && !crc_good) |=> (!eof_irq && $stable(fcs_valid)));
  assert_short_keeps_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && short_frm) |=> ($stable(fcs_valid) && !ack_accepted));
endmodule

// File: rtl/fcs_rx_checker.sv
module fcs_rx_checker
  import fcsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              oct_valid,
  input  logic [DATA_W-1:0] oct_data,
  input  logic              aack_mode,
  input  logic              aret_mode,
  output logic              eof_irq,
  output logic              ack_accepted,
  output logic              fcs_valid
);
  logic acc_clr, acc_en, fin, short_frm, rem_zero;

  fcsc_frame_seq #(.LW(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_len(frm_len),
    .oct_valid(oct_valid), .acc_clr(acc_clr), .acc_en(acc_en),
    .fin(fin), .short_frm(short_frm)
  );

  fcsc_crc_acc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY_REFL)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en), .din(oct_data),
    .rem_zero_next(rem_zero)
  );

  fcsc_verdict u_vrd (
    .clk(clk), .rst_n(rst_n), .fin(fin), .short_frm(short_frm),
    .crc_good(rem_zero), .aack_mode(aack_mode), .aret_mode(aret_mode),
    .eof_irq(eof_irq), .ack_accepted(ack_accepted), .fcs_valid(fcs_valid)
  );

  assert_status_only_on_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eof_irq |-> $stable(fcs_valid));
  assert_ack_with_good_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_accepted |-> (eof_irq && fcs_valid));
endmodule

// File: tb/sim_fcs_rx_checker.sv
module sim_fcs_rx_checker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frm_start, oct_valid, aack_mode, aret_mode;
  logic [6:0] frm_len;
  logic [7:0] oct_data;
  logic       eof_irq, ack_accepted, fcs_valid;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] fq[$];

  // reference state
  bit         m_active;
  int         m_len, m_cnt;
  bit [15:0]  m_crc;
  bit         e_eof, e_ack, e_stat;

  always #4 clk = ~clk;

  fcs_rx_checker u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_len(frm_len),
    .oct_valid(oct_valid), .oct_data(oct_data), .aack_mode(aack_mode),
    .aret_mode(aret_mode), .eof_irq(eof_irq), .ack_accepted(ack_accepted),
    .fcs_valid(fcs_valid)
  );

  function automatic bit [15:0] crc_byte(bit [15:0] c, bit [7:0] d);
    for (int i = 0; i < 8; i++) begin
      bit fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic model_finish();
    bit good;
    m_active = 0;
    if (m_len < 2) begin
      e_eof = 1;
    end else begin
      good = (m_crc == 16'h0000);
      if (!(aack_mode && !good)) begin
        e_eof = 1;
        e_stat = good;
        if (aret_mode && good) e_ack = 1;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_len = 0; m_cnt = 0; m_crc = 0;
      e_eof = 0; e_ack = 0; e_stat = 0;
    end else begin
      e_eof = 0; e_ack = 0;
      if (frm_start) begin
        m_len = int'(frm_len); m_cnt = 0; m_crc = 0; m_active = 1;
        if (m_len == 0) model_finish();
      end else if (m_active && oct_valid) begin
        m_crc = crc_byte(m_crc, oct_data);
        m_cnt++;
        if (m_cnt == m_len) model_finish();
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("R4 eof_irq", eof_irq, e_eof);
      chk("R8 ack_accepted", ack_accepted, e_ack);
      chk("R3 fcs_valid", fcs_valid, e_stat);
    end
  end

  task automatic build(int n, bit good, int seed);
    bit [15:0] c = 0;
    fq.delete();
    for (int i = 0; i < n - 2; i++) begin
      fq.push_back(8'((i * 37 + seed * 11 + 5) & 8'hff));
      c = crc_byte(c, fq[i]);
    end
    if (n >= 2) begin
      fq.push_back(c[7:0]);
      fq.push_back(c[15:8]);
      if (!good) fq[0] = fq[0] ^ 8'h01;
    end else begin
      for (int i = 0; i < n; i++) fq.push_back(8'h5a);
    end
  endtask

  // ends at the negedge after the last octet edge
  task automatic send(int n, int gap);
    @(negedge clk);
    frm_start = 1; frm_len = 7'(n); oct_valid = 1; oct_data = 8'hff;
    @(negedge clk);
    frm_start = 0; oct_valid = 0;
    for (int i = 0; i < fq.size(); i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        oct_valid = 0;
        @(negedge clk);
      end
      oct_valid = 1; oct_data = fq[i];
      @(negedge clk);
    end
    oct_valid = 0;
  endtask

  task automatic frame(int n, bit good, int seed, int gap);
    build(n, good, seed);
    send(n, gap);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; frm_start = 0; frm_len = 0; oct_valid = 0; oct_data = 0;
    aack_mode = 0; aret_mode = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset fcs_valid", fcs_valid, 1'b0);
    chk("R2 reset eof_irq", eof_irq, 1'b0);
    chk("R2 reset ack_accepted", ack_accepted, 1'b0);
    rst_n = 1;
    idle(2);

    frame(5, 1, 1, 0);
    chk("R1 good len5 status", fcs_valid, 1'b1);
    chk("R4 good len5 eof", eof_irq, 1'b1);
    idle(1);
    chk("R4 eof is one cycle", eof_irq, 1'b0);
    frame(9, 0, 2, 3);
    chk("R1 bad len9 status", fcs_valid, 1'b0);
    frame(2, 1, 3, 0);
    chk("R1 len2 empty payload good", fcs_valid, 1'b1);
    frame(1, 1, 4, 0);
    chk("R5 len1 eof", eof_irq, 1'b1);
    chk("R5 len1 status held", fcs_valid, 1'b1);
    @(negedge clk);
    frm_start = 1; frm_len = 0;
    @(negedge clk);
    frm_start = 0;
    chk("R5 len0 eof", eof_irq, 1'b1);
    chk("R5 len0 status held", fcs_valid, 1'b1);
    idle(2);

    // stray octets while idle
    for (int i = 0; i < 4; i++) begin
      oct_valid = 1; oct_data = 8'(8'h33 + i);
      @(negedge clk);
    end
    oct_valid = 0;
    chk("R10 no event from stray octets", eof_irq, 1'b0);
    frame(6, 1, 5, 2);
    chk("R10 stray octets kept out of crc", fcs_valid, 1'b1);

    aack_mode = 1;
    frame(8, 0, 6, 0);
    chk("R6 aack bad no eof", eof_irq, 1'b0);
    chk("R6 aack bad status held", fcs_valid, 1'b1);
    frame(4, 0, 7, 0);
    frame(7, 1, 8, 0);
    chk("R7 aack good eof", eof_irq, 1'b1);
    chk("R7 aack good status", fcs_valid, 1'b1);
    aack_mode = 0;

    aret_mode = 1;
    frame(5, 1, 9, 0);
    chk("R8 aret good ack", ack_accepted, 1'b1);
    frame(5, 0, 10, 0);
    chk("R8 aret bad no ack", ack_accepted, 1'b0);
    chk("R8 aret bad eof", eof_irq, 1'b1);
    chk("R8 aret bad status", fcs_valid, 1'b0);
    frame(1, 1, 11, 0);
    chk("R5 aret short no ack", ack_accepted, 1'b0);
    aret_mode = 0;

    // abort partway then restart with a good frame
    build(10, 0, 12);
    @(negedge clk);
    frm_start = 1; frm_len = 7'd10;
    @(negedge clk);
    frm_start = 0;
    for (int i = 0; i < 4; i++) begin
      oct_valid = 1; oct_data = fq[i];
      @(negedge clk);
    end
    oct_valid = 0;
    frame(6, 1, 13, 0);
    chk("R9 restart good", fcs_valid, 1'b1);
    chk("R9 restart eof", eof_irq, 1'b1);

    frame(127, 1, 14, 5);
    chk("R1 len127 good", fcs_valid, 1'b1);
    frame(127, 0, 15, 0);
    chk("R1 len127 bad", fcs_valid, 1'b0);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    miscompares++;
    $display("FAIL watchdog expired (R4 end of frame not reached)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule